// File: doc/BRIEF.md
# MII PHY-Side Signal Controller

This block is the physical-layer end of a Media Independent Interface. It sits between a MAC and an abstract coding sublayer. It produces the transmit and receive nibble clocks from a faster core clock. On each rising edge of the transmit clock it captures a nibble from the MAC and hands a 5-bit symbol onward. On the receive side it turns symbols into data-valid, data and error toward the MAC. From the activity on both paths it derives carrier sense and collision.

Several control inputs steer the block, and each is a plain input:

- **Speed.** A fast mode divides the core clock by `DIV_FAST` and a slow mode divides it by `DIV_SLOW`, a 10:1 ratio matching 100 Mb/s and 10 Mb/s.
- **Repeater mode.** Carrier sense ignores the local transmitter.
- **Code-group bypass mode.** The MAC error pins carry the fifth bit of raw 5-bit symbols.
- **Isolate mode.** The MAC-facing outputs are released to high impedance.
- **Power-save.** In fast mode, this bit parks the receive clock low while no receive activity is present.

In slow mode the block adds a signal-quality test pulse on collision after each transmission. Also in slow mode, data-valid opens only once a start-of-frame delimiter has been seen.

Top module: `mii_phy_ctrl`

## Requirements
- R1: At each rising edge of `mii_tx_clk`, `pcs_tx_valid` takes the sampled `mii_tx_en`. With enable high and error low, and outside bypass, `pcs_tx_code` becomes `{1'b0, mii_txd}` and `pcs_tx_err` is 0. With enable low, code and error are 0, whatever `mii_tx_er` and `mii_txd` hold.
- R2: Outside bypass, when enable and `mii_tx_er` are both high at a rising edge, `pcs_tx_code` becomes the error symbol 5'b00100 and `pcs_tx_err` is 1.
- R3: In bypass mode, a sampled enable gives `pcs_tx_code = {mii_tx_er, mii_txd}` and `pcs_tx_err = 0`.
- R4: Outside repeater mode, `mii_crs` is high exactly when the enable or `pcs_rx_act` sampled at the last rising edge was high.
- R5: In repeater mode, `mii_crs` follows only the sampled `pcs_rx_act`.
- R6: `mii_col` is high whenever the sampled enable and the sampled `pcs_rx_act` are both high.
- R7: In slow mode, `mii_col` also pulses after a transmission. If edge k samples enable low after edge k-1 sampled it high, `mii_col` is high after edges k+3, k+4 and k+5, unless enable returns high or the block enters fast mode. In fast mode no such pulse occurs.
- R8: In fast mode (not bypass), after each rising edge `mii_rx_dv` equals the sampled `pcs_rx_act`. `mii_rxd` then equals `pcs_rx_sym[3:0]` while data-valid is high and 0 otherwise.
- R9: In slow mode, `mii_rx_dv` rises at the edge that samples nibble 4'hD directly after nibble 4'h5, both with `pcs_rx_act` high. It then stays high while activity stays high and falls at the first edge sampling activity low. Nibbles before the delimiter give `mii_rxd = 0`.
- R10: Outside bypass, `mii_rx_er` equals `pcs_rx_bad` at each edge where data-valid is high, and is 0 otherwise. In bypass, data-valid follows activity, `mii_rxd` carries `pcs_rx_sym[3:0]` and `mii_rx_er` carries `pcs_rx_sym[4]` while activity is high, and both are 0 otherwise.
- R11: With power-save set in fast mode, an edge that samples `pcs_rx_act` low keeps `mii_rx_clk` low for the following clock period. With activity high, or with power-save clear, `mii_rx_clk` pulses together with `mii_tx_clk`.
- R12: While `cfg_isolate` is high, `mac_oe` is 0 and every MAC-facing output is high impedance. The internal paths keep running.
- R13: In fast mode `mii_tx_clk` rises every `DIV_FAST` core cycles (default 2). In slow mode it rises every `DIV_SLOW` core cycles (default 20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_fast | input | 1 | 1 = fast (100 Mb/s) mode, 0 = slow (10 Mb/s) |
| cfg_repeater | input | 1 | carrier sense follows receive activity only |
| cfg_bypass | input | 1 | raw 5-bit code groups on the data and error pins |
| cfg_isolate | input | 1 | release all MAC-facing outputs |
| cfg_rxclk_save | input | 1 | park receive clock low when idle (fast mode) |
| mii_tx_clk | output | 1 | transmit nibble clock to the MAC |
| mii_tx_en | input | 1 | transmit enable from the MAC |
| mii_tx_er | input | 1 | transmit error request, or symbol bit 4 in bypass |
| mii_txd | input | 4 | transmit nibble |
| mii_rx_clk | output | 1 | receive nibble clock to the MAC |
| mii_rx_dv | output | 1 | receive data valid |
| mii_rxd | output | 4 | receive nibble |
| mii_rx_er | output | 1 | receive error, or symbol bit 4 in bypass |
| mii_crs | output | 1 | carrier sense |
| mii_col | output | 1 | collision |
| mac_oe | output | 1 | 1 while MAC-facing outputs are driven |
| pcs_tx_valid | output | 1 | symbol toward the coder is valid |
| pcs_tx_code | output | 5 | transmit symbol |
| pcs_tx_err | output | 1 | error symbol requested |
| pcs_rx_act | input | 1 | receive path is non-idle |
| pcs_rx_sym | input | 5 | receive symbol (bits 3:0 are the nibble) |
| pcs_rx_bad | input | 1 | receive symbol is an invalid code group |

## Verification
- **Delimiter tracker.** If the tracker holds a stale last nibble or a stale lock, slow-mode data-valid rises one edge early or late, or reopens after activity drops. This shows on the first frame that follows.
- **Post-transmit counter.** If this counter misbehaves, collision pulses at the wrong edge, for the wrong length, or even in fast mode. The fault is visible within six nibble periods of the fall of enable.
- **Clock gate and divider.** A wrong gate or divider state shows as a receive clock pulse that is present or missing while activity is low, or as a rise spacing other than 2 or 20 core cycles. Either appears within one period.
- **Mode switches.** Random traffic across all mode combinations compares every output after each rising edge. Any wrong internal state therefore surfaces at the next edge that depends on it.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;

    localparam int NIB_W = 4;
    localparam int SYM_W = NIB_W + 1;

    // symbol sent when the MAC requests an error code group
    localparam logic [SYM_W-1:0] TX_ERR_SYM = 5'b00100;
    // nibble pair that opens a frame in slow mode
    localparam logic [NIB_W-1:0] PRE_NIB    = 4'h5;
    localparam logic [NIB_W-1:0] SFD_NIB    = 4'hD;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [SYM_W-1:0] code;
    } tx_sym_t;

    typedef struct packed {
        logic             dv;
        logic             er;
        logic [NIB_W-1:0] nib;
    } rx_out_t;

    function automatic logic sfd_pair(input logic [NIB_W-1:0] last,
                                      input logic [NIB_W-1:0] cur);
        return (last == PRE_NIB) && (cur == SFD_NIB);
    endfunction

    function automatic tx_sym_t tx_encode(input logic en,
                                          input logic er,
                                          input logic bypass,
                                          input logic [NIB_W-1:0] d);
        tx_sym_t s;
        s.valid = en;
        s.err   = 1'b0;
        s.code  = '0;
        if (en) begin
            if (bypass) begin
                s.code = {er, d};
            end else if (er) begin
                s.code = TX_ERR_SYM;
                s.err  = 1'b1;
            end else begin
                s.code = {1'b0, d};
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/mii_clk_div.sv
module mii_clk_div #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic save,
    input  logic rx_act,
    output logic tick,
    output logic tx_clk,
    output logic rx_clk
);
    localparam int CW = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt, cnt_nxt, lim, half;
    logic          fast_q, lvl, gate;
    logic          mode_chg;

    always_comb begin
        lim      = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
        half     = fast ? CW'(DIV_FAST / 2) : CW'(DIV_SLOW / 2);
        mode_chg = (fast != fast_q);
        if (mode_chg || cnt >= lim) cnt_nxt = '0;
        else                        cnt_nxt = cnt + 1'b1;
        tick     = !mode_chg && (cnt_nxt == half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            lvl    <= 1'b0;
            gate   <= 1'b0;
            fast_q <= 1'b1;
        end else begin
            fast_q <= fast;
            cnt    <= cnt_nxt;
            lvl    <= !mode_chg && (cnt_nxt >= half);
            if (tick) gate <= save && fast && !rx_act;
        end
    end

    assign tx_clk = lvl;
    assign rx_clk = lvl && !gate;
endmodule

// File: rtl/mii_tx_cap.sv
module mii_tx_cap
    import mii_phy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bypass,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output tx_sym_t          sym
);
    always_ff @(posedge clk) begin
        if (rst)       sym <= '0;
        else if (tick) sym <= tx_encode(tx_en, tx_er, bypass, txd);
    end
endmodule

// File: rtl/mii_rx_frame.sv
module mii_rx_frame
    import mii_phy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             fast,
    input  logic             bypass,
    input  logic             act,
    input  logic [SYM_W-1:0] sym,
    input  logic             bad,
    output rx_out_t          rxo
);
    logic [NIB_W-1:0] prev;
    logic             locked;
    logic             direct, hit, dv_n;

    always_comb begin
        direct = fast || bypass;
        hit    = sfd_pair(prev, sym[NIB_W-1:0]);
        dv_n   = act && (direct || locked || hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            locked <= 1'b0;
            rxo    <= '0;
        end else if (tick) begin
            prev    <= act ? sym[NIB_W-1:0] : '0;
            locked  <= !direct && act && (locked || hit);
            rxo.dv  <= dv_n;
            rxo.nib <= dv_n ? sym[NIB_W-1:0] : '0;
            rxo.er  <= bypass ? (act && sym[SYM_W-1]) : (dv_n && bad);
        end
    end
endmodule

// File: rtl/mii_carrier.sv
module mii_carrier #(
    parameter int SQE_GAP = 3,
    parameter int SQE_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fast,
    input  logic repeater,
    input  logic tx_en,
    input  logic rx_act,
    output logic crs,
    output logic col
);
    localparam int TOT = SQE_GAP + SQE_LEN;
    localparam int SW  = $clog2(TOT + 1);

    logic          tx_on, rx_on;
    logic [SW-1:0] w;
    logic          sqe;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_on <= 1'b0;
            rx_on <= 1'b0;
            w     <= '0;
        end else if (tick) begin
            tx_on <= tx_en;
            rx_on <= rx_act;
            if (fast || tx_en)         w <= '0;
            else if (tx_on)            w <= SW'(1);
            else if (w == SW'(TOT))    w <= '0;
            else if (w != '0)          w <= w + 1'b1;
        end
    end

    always_comb begin
        sqe = (w > SW'(SQE_GAP));
        crs = repeater ? rx_on : (tx_on || rx_on);
        col = (tx_on && rx_on) || sqe;
    end
endmodule

// File: rtl/mii_phy_ctrl.sv
module mii_phy_ctrl
    import mii_phy_pkg::*;
#(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 20,
    parameter int SQE_GAP  = 3,
    parameter int SQE_LEN  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_fast,
    input  logic             cfg_repeater,
    input  logic             cfg_bypass,
    input  logic             cfg_isolate,
    input  logic             cfg_rxclk_save,
    output logic             mii_tx_clk,
    input  logic             mii_tx_en,
    input  logic             mii_tx_er,
    input  logic [NIB_W-1:0] mii_txd,
    output logic             mii_rx_clk,
    output logic             mii_rx_dv,
    output logic [NIB_W-1:0] mii_rxd,
    output logic             mii_rx_er,
    output logic             mii_crs,
    output logic             mii_col,
    output logic             mac_oe,
    output logic             pcs_tx_valid,
    output logic [SYM_W-1:0] pcs_tx_code,
    output logic             pcs_tx_err,
    input  logic             pcs_rx_act,
    input  logic [SYM_W-1:0] pcs_rx_sym,
    input  logic             pcs_rx_bad
);
    logic             tick_i, tx_clk_i, rx_clk_i;
    logic             crs_i, col_i;
    logic             dv_i;
    logic [NIB_W-1:0] nib_i;
    tx_sym_t          txs;
    rx_out_t          rxo;

    mii_clk_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk(clk), .rst(rst), .fast(cfg_fast), .save(cfg_rxclk_save),
        .rx_act(pcs_rx_act), .tick(tick_i), .tx_clk(tx_clk_i), .rx_clk(rx_clk_i)
    );

    mii_tx_cap u_tx (
        .clk(clk), .rst(rst), .tick(tick_i), .bypass(cfg_bypass),
        .tx_en(mii_tx_en), .tx_er(mii_tx_er), .txd(mii_txd), .sym(txs)
    );

    mii_rx_frame u_rx (
        .clk(clk), .rst(rst), .tick(tick_i), .fast(cfg_fast), .bypass(cfg_bypass),
        .act(pcs_rx_act), .sym(pcs_rx_sym), .bad(pcs_rx_bad), .rxo(rxo)
    );

    mii_carrier #(.SQE_GAP(SQE_GAP), .SQE_LEN(SQE_LEN)) u_car (
        .clk(clk), .rst(rst), .tick(tick_i), .fast(cfg_fast), .repeater(cfg_repeater),
        .tx_en(mii_tx_en), .rx_act(pcs_rx_act), .crs(crs_i), .col(col_i)
    );

    assign dv_i         = rxo.dv;
    assign nib_i        = rxo.nib;
    assign pcs_tx_valid = txs.valid;
    assign pcs_tx_code  = txs.code;
    assign pcs_tx_err   = txs.err;
    assign mac_oe       = !cfg_isolate;

    assign mii_tx_clk = cfg_isolate ? 1'bz : tx_clk_i;
    assign mii_rx_clk = cfg_isolate ? 1'bz : rx_clk_i;
    assign mii_rx_dv  = cfg_isolate ? 1'bz : rxo.dv;
    assign mii_rxd    = cfg_isolate ? 4'bzzzz : rxo.nib;
    assign mii_rx_er  = cfg_isolate ? 1'bz : rxo.er;
    assign mii_crs    = cfg_isolate ? 1'bz : crs_i;
    assign mii_col    = cfg_isolate ? 1'bz : col_i;
endmodule

// File: rtl/mii_phy_ctrl_chk.sv
module mii_phy_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       fast,
    input logic       bypass,
    input logic       repeater,
    input logic       save,
    input logic       tx_en,
    input logic       tx_er,
    input logic       rx_act,
    input logic       tx_valid,
    input logic       tx_err,
    input logic       dv,
    input logic [3:0] nib,
    input logic       crs,
    input logic       rx_clk,
    input logic       tx_clk
);
    // R1
    tx_cap_chk: assert property (@(posedge clk) disable iff (rst)
        tick && tx_en |=> tx_valid);

    // R2
    tx_err_chk: assert property (@(posedge clk) disable iff (rst)
        tick && tx_en && tx_er && !bypass |=> tx_err);

    // R9
    sfd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(fast) && !$past(bypass) && $rose(dv) |-> nib == 4'hD);

    // R5
    rep_crs_chk: assert property (@(posedge clk) disable iff (rst)
        tick && repeater && !rx_act |=> (!repeater || !crs));

    // R11
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tick && fast && save && !rx_act |=> !rx_clk);

    // R13
    clk_rise_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> tx_clk);
endmodule

bind mii_phy_ctrl mii_phy_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick_i), .fast(cfg_fast), .bypass(cfg_bypass),
    .repeater(cfg_repeater), .save(cfg_rxclk_save), .tx_en(mii_tx_en),
    .tx_er(mii_tx_er), .rx_act(pcs_rx_act), .tx_valid(pcs_tx_valid),
    .tx_err(pcs_tx_err), .dv(dv_i), .nib(nib_i), .crs(crs_i),
    .rx_clk(rx_clk_i), .tx_clk(tx_clk_i)
);

// File: tb/mii_phy_ctrl_test.sv
module mii_phy_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic f = 1'b1, rp = 1'b0, bp = 1'b0, iso = 1'b0, ps = 1'b0;
    logic en = 1'b0, er = 1'b0, act = 1'b0, bad = 1'b0;
    logic [3:0] txd = '0;
    logic [4:0] sym = '0;

    wire       tx_clk, rx_clk, rx_dv, rx_er, crs, col, oe, tv, terr;
    wire [3:0] rxd;
    wire [4:0] tcode;

    int chk_cnt = 0, err_cnt = 0;
    bit done = 0;
    logic last_lvl = 1'b0;
    // requirement-level model state
    logic [3:0] m_prev = '0;
    bit m_locked = 0, m_txon = 0;
    int m_s = 0;

    mii_phy_ctrl uut (
        .clk(clk), .rst(rst), .cfg_fast(f), .cfg_repeater(rp), .cfg_bypass(bp),
        .cfg_isolate(iso), .cfg_rxclk_save(ps), .mii_tx_clk(tx_clk),
        .mii_tx_en(en), .mii_tx_er(er), .mii_txd(txd), .mii_rx_clk(rx_clk),
        .mii_rx_dv(rx_dv), .mii_rxd(rxd), .mii_rx_er(rx_er), .mii_crs(crs),
        .mii_col(col), .mac_oe(oe), .pcs_tx_valid(tv), .pcs_tx_code(tcode),
        .pcs_tx_err(terr), .pcs_rx_act(act), .pcs_rx_sym(sym), .pcs_rx_bad(bad)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int a, input int e);
        chk_cnt++;
        if (a != e) begin
            err_cnt++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, a, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", err_cnt, chk_cnt);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        chk("WD", "watchdog expired", 1, 0);
        finish_run();
    end

    // returns cycles waited; sampled at a negedge right after a rise
    task automatic wait_rise(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (tx_clk === 1'b1 && last_lvl === 1'b0) begin
                last_lvl = 1'b1;
                break;
            end
            last_lvl = tx_clk;
            if (n > 100) begin
                chk("R13", "no transmit clock rise", 0, 1);
                break;
            end
        end
    endtask

    // one nibble period: predict, wait for the capturing edge, compare
    task automatic step();
        int n, ns;
        bit direct, sfd, e_dv, e_er, e_sqe;
        int e_code, e_rxd;
        string rq;
        direct = f || bp;
        sfd    = (m_prev == 4'h5) && (sym[3:0] == 4'hD);
        e_dv   = act && (direct || m_locked || sfd);
        e_rxd  = e_dv ? int'(sym[3:0]) : 0;
        e_er   = bp ? (act && sym[4]) : (e_dv && bad);
        e_code = !en ? 0 : bp ? int'({er, txd}) : er ? 4 : int'(txd);
        if (f || en)          ns = 0;
        else if (m_txon)      ns = 1;
        else if (m_s == 6)    ns = 0;
        else if (m_s != 0)    ns = m_s + 1;
        else                  ns = 0;
        e_sqe = (ns > 3);
        wait_rise(n);
        rq = bp ? "R3" : (en && er) ? "R2" : "R1";
        chk(rq, "pcs_tx_valid", tv, en);
        chk(rq, "pcs_tx_code", tcode, e_code);
        chk(rq, "pcs_tx_err", terr, (en && er && !bp));
        rq = bp ? "R10" : f ? "R8" : "R9";
        chk(rq, "rx_dv", rx_dv, e_dv);
        chk(rq, "rxd", rxd, e_rxd);
        chk("R10", "rx_er", rx_er, e_er);
        chk(rp ? "R5" : "R4", "crs", crs, rp ? act : (en || act));
        chk(ns != 0 ? "R7" : "R6", "col", col, (en && act) || e_sqe);
        chk("R11", "rx_clk", rx_clk, !(ps && f && !act));
        m_prev   = act ? sym[3:0] : 4'h0;
        m_locked = !direct && act && (m_locked || sfd);
        m_s      = ns;
        m_txon   = en;
    endtask

    task automatic set_in(input bit t_en, input bit t_er, input logic [3:0] d,
                          input bit r_act, input logic [4:0] s, input bit b);
        en = t_en; er = t_er; txd = d; act = r_act; sym = s; bad = b;
    endtask

    initial begin
        int n, cols;
        logic [3:0] frame [7];
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1", "reset tx_valid", tv, 0);
        chk("R4", "reset crs", crs, 0);
        chk("R6", "reset col", col, 0);
        chk("R8", "reset rx_dv", rx_dv, 0);
        chk("R13", "reset tx_clk", tx_clk, 0);
        rst = 1'b0;

        // R13 clock spacing in both speeds
        wait_rise(n); wait_rise(n);
        chk("R13", "fast period", n, 2);
        f = 1'b0;
        wait_rise(n); wait_rise(n);
        chk("R13", "slow period", n, 20);
        f = 1'b1;
        wait_rise(n);

        // fast transmit with an error request, ignored error while idle
        set_in(1, 0, 4'hA, 0, 0, 0); step();
        set_in(1, 1, 4'h3, 0, 0, 0); step();
        set_in(0, 1, 4'hF, 0, 0, 0); step();
        // bypass transmit and receive
        bp = 1'b1;
        set_in(1, 1, 4'h6, 1, 5'h1C, 0); step();
        set_in(0, 0, 4'h0, 1, 5'h05, 0); step();
        set_in(0, 0, 4'h0, 0, 5'h1F, 0); step();
        bp = 1'b0;
        // fast receive with a bad code group (R10)
        set_in(0, 0, 0, 1, 5'h05, 0); step();
        set_in(0, 0, 0, 1, 5'h07, 1); step();
        set_in(0, 0, 0, 0, 5'h07, 1); step();

        // power-save gating (R11)
        ps = 1'b1;
        set_in(0, 0, 0, 0, 0, 0); step(); step();
        set_in(0, 0, 0, 1, 5'h02, 0); step();
        set_in(0, 0, 0, 0, 0, 0); step();
        ps = 1'b0;

        // slow-mode frame: data-valid opens on the delimiter (R9)
        f = 1'b0;
        frame = '{4'h5, 4'h5, 4'h5, 4'h5, 4'hD, 4'hA, 4'h3};
        foreach (frame[i]) begin
            set_in(0, 0, 0, 1, {1'b0, frame[i]}, i == 6); step();
            if (i == 3) chk("R9", "dv before delimiter", rx_dv, 0);
            if (i == 4) chk("R9", "dv at delimiter", rx_dv, 1);
        end
        set_in(0, 0, 0, 0, 0, 0); step();
        chk("R9", "dv after activity drop", rx_dv, 0);

        // slow-mode post-transmit pulse (R7)
        set_in(1, 0, 4'h1, 0, 0, 0); step(); step();
        cols = 0;
        for (int i = 0; i < 9; i++) begin
            set_in(0, 0, 0, 0, 0, 0); step();
            cols += col;
        end
        chk("R7", "slow pulse length", cols, 3);
        // fast: no pulse
        f = 1'b1;
        set_in(1, 0, 4'h1, 0, 0, 0); step();
        cols = 0;
        for (int i = 0; i < 8; i++) begin
            set_in(0, 0, 0, 0, 0, 0); step();
            cols += col;
        end
        chk("R7", "fast pulse count", cols, 0);

        // repeater: own transmit does not raise carrier (R5)
        rp = 1'b1;
        set_in(1, 0, 4'h9, 0, 0, 0); step();
        set_in(1, 0, 4'h9, 1, 5'h09, 0); step();
        set_in(0, 0, 0, 0, 0, 0); step();
        rp = 1'b0;

        // isolate (R12): outputs released, internal capture continues
        set_in(0, 0, 0, 0, 0, 0);
        iso = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", "mac_oe in isolate", oe, 0);
        en = 1'b1; txd = 4'h7;
        repeat (4) @(negedge clk);
        chk("R12", "tx capture during isolate", tcode, 7);
        en = 1'b0;
        repeat (40) @(negedge clk);
        iso = 1'b0;
        last_lvl = 1'b1;
        m_prev = '0; m_locked = 0; m_s = 0; m_txon = 0;
        wait_rise(n);
        chk("R12", "mac_oe after isolate", oe, 1);

        // constrained random traffic across mode combinations
        for (int blk = 0; blk < 40; blk++) begin
            f  = $urandom_range(0, 3) != 0;
            rp = $urandom_range(0, 3) == 0;
            bp = $urandom_range(0, 4) == 0;
            ps = $urandom_range(0, 1);
            for (int k = 0; k < 40; k++) begin
                logic [4:0] s;
                s = 5'($urandom);
                if ($urandom_range(0, 3) == 0) s[3:0] = $urandom_range(0, 1) ? 4'h5 : 4'hD;
                set_in($urandom_range(0, 2) != 0, $urandom_range(0, 5) == 0, 4'($urandom),
                       $urandom_range(0, 3) != 0, s, $urandom_range(0, 7) == 0);
                step();
            end
        end
        finish_run();
    end
endmodule